// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two 16-bit timer/counter units of the kind found beside small 8-bit processor cores. Each unit has a 4-bit configuration nibble and a few control bits. The nibble holds an operating mode, a timer-or-counter select and a gate enable. The control bits are a run bit, an overflow flag and a clock-speed select. A unit counts either ticks of its own prescaler or falling edges on an external count input. The prescaler gives either one tick every clock or one tick every twelve clocks. When the count wraps, the unit raises its overflow flag. The flag is cleared by a per-unit acknowledge pulse or by a host write.

A simple register port lets a host read and write both count bytes of each unit, the shared configuration register and the shared control register. Reads are combinational on the address. Writes take effect at the next clock edge and win over any counting in that same cycle. Unit 0 has a split mode. In that mode its low byte becomes an 8-bit counter and its high byte becomes an 8-bit timer that borrows unit 1's run bit and overflow flag, while unit 1's count stays frozen.

Top module: `dual_timer`

## Requirements
- R1: After reset, every register reads 0x00 and both overflow flags are 0.
- R2: Register map by `addr`: 0 = unit 0 low byte, 1 = unit 0 high byte, 2 = unit 1 low byte, 3 = unit 1 high byte, 4 = configuration, 5 = control. The configuration register holds unit 0 in bits [3:0] and unit 1 in bits [7:4]; within each nibble, bits [1:0] are the mode, bit 2 selects counter (1) or timer (0), and bit 3 is the gate enable. The control register bits are: 0 = run0, 1 = flag0, 2 = fast0, 4 = run1, 5 = flag1, 6 = fast1, and bits 3 and 7 read as 0.
- R3: Mode 1 counts the full 16 bits {high, low}. Going from 0xFFFF to 0x0000 sets the unit's flag.
- R4: Mode 0 counts 13 bits, formed from the high byte and the low 5 bits of the low byte. Bits [7:5] of the low byte are neither counted nor changed. Wrapping from all ones sets the flag.
- R5: Mode 2 increments the low byte. When the low byte wraps from 0xFF, it loads the high byte instead of 0 and sets the flag. The high byte does not change.
- R6: In counter mode, one count occurs for each 1-to-0 transition of the unit's count input, taken after a two-flop synchronizer. A 0-to-1 transition does not count.
- R7: A unit counts only while its run bit is 1 and either its gate bit is 0 or its gate pin is 1.
- R8: With fast = 0, a timer advances once every 12 clocks, the first advance landing on the 12th clock after run is set. With fast = 1, it advances every clock.
- R9: When unit 0 is in mode 3, its low byte is an 8-bit counter that uses unit 0's counter select, gate, run bit and flag.
- R10: When unit 0 is in mode 3, its high byte is an 8-bit timer driven by unit 0's prescaler. It runs on run1 alone and sets flag1 when it wraps, and unit 1's count stays frozen.
- R11: When unit 1's own mode is 3, unit 1 holds its count.
- R12: A high `irq_ack[u]` clears flag u. A host write to the control register in the same cycle sets the flag to the written value instead, and an overflow in the same cycle leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Register read data (combinational) |
| cnt_in | input | 2 | External count inputs, one per unit |
| gate_pin | input | 2 | Gate qualifying pins, one per unit |
| irq_ack | input | 2 | Overflow acknowledge, one per unit |
| ovf_flag | output | 2 | Overflow flags |

## Verification
The bench targets the wrap points of each mode. It preloads values just below rollover and reads the count a known number of clocks later. In mode 0, a design that counted bits [7:5] of the low byte or cleared them would show the wrong low byte. In mode 2, a design that wrapped to zero instead of reloading would show a low byte near 0x01 rather than just above the reload value. In split mode, the bench checks that both halves wrap and set separate flags while unit 1 keeps its preloaded value, so a design that let unit 1 run on, or routed the high-byte wrap to flag0, would be caught. The bench also checks the divide-by-12 phase exactly at 35 and 36 clocks, that a closed gate stops counting, and that a host write holds a flag set against an acknowledge arriving in the same cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    TM_13BIT = 2'd0,
    TM_16BIT = 2'd1,
    TM_RELOAD = 2'd2,
    TM_SPLIT = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ctr;
    tmr_mode_e mode;
  } tmr_cfg_t;

  typedef struct packed {
    logic       ovf;
    logic [7:0] hi;
    logic [7:0] lo;
  } tmr_step_t;

  // One count step of a unit in modes 0..2; mode 3 leaves the value unchanged.
  function automatic tmr_step_t tmr_step(tmr_mode_e m, logic [7:0] lo, logic [7:0] hi);
    tmr_step_t  r;
    logic [12:0] v13;
    logic [15:0] v16;
    r = '{ovf: 1'b0, hi: hi, lo: lo};
    case (m)
      TM_13BIT: begin
        v13   = {hi, lo[4:0]};
        r.ovf = &v13;
        v13   = v13 + 13'd1;
        r.hi  = v13[12:5];
        r.lo  = {lo[7:5], v13[4:0]};
      end
      TM_16BIT: begin
        v16   = {hi, lo};
        r.ovf = &v16;
        v16   = v16 + 16'd1;
        r.hi  = v16[15:8];
        r.lo  = v16[7:0];
      end
      TM_RELOAD: begin
        r.ovf = &lo;
        r.lo  = (&lo) ? hi : lo + 8'd1;
      end
      default: r.ovf = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fast,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = en & (fast | (cnt_q == LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!en) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + CW'(1);
  end

  // R8
  slow_tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast && tick) |=> (!tick || fast));

endmodule

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];

  // R6
  single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/dual_timer.sv
module dual_timer #(
  parameter int DIV         = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic [1:0] cnt_in,
  input  logic [1:0] gate_pin,
  input  logic [1:0] irq_ack,
  output logic [1:0] ovf_flag
);
  import tmr_pkg::*;

  localparam int NU = 2;

  logic [7:0] lo_q [NU];
  logic [7:0] hi_q [NU];
  logic [7:0] lo_n [NU];
  logic [7:0] hi_n [NU];
  tmr_cfg_t   cfg_q [NU];
  logic [NU-1:0] run_q, flag_q, fast_q;

  logic [NU-1:0] fall, tick, pre_en, cnt_en, evt, ovf_ev;
  logic          split, hold1, lo_adv_s, hi_adv_s, wr_ctrl;
  tmr_step_t     st [NU];

  assign split   = (cfg_q[0].mode == TM_SPLIT);
  assign hold1   = split | (cfg_q[1].mode == TM_SPLIT);
  assign wr_ctrl = wr_en && (addr == 3'd5);
  assign pre_en  = {run_q[1], run_q[0] | (split & run_q[1])};

  for (genvar u = 0; u < NU; u++) begin : g_unit
    tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(cnt_in[u]), .fall(fall[u]));
    tmr_prescale #(.DIV(DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .en(pre_en[u]), .fast(fast_q[u]), .tick(tick[u]));
    assign cnt_en[u] = run_q[u] & (~cfg_q[u].gate | gate_pin[u]);
    assign evt[u]    = cnt_en[u] & (cfg_q[u].ctr ? fall[u] : tick[u]);
    assign st[u]     = tmr_step(cfg_q[u].mode, lo_q[u], hi_q[u]);
  end

  assign lo_adv_s = split & evt[0];
  assign hi_adv_s = split & run_q[1] & tick[0];

  always_comb begin
    lo_n[0] = lo_q[0];
    hi_n[0] = hi_q[0];
    lo_n[1] = lo_q[1];
    hi_n[1] = hi_q[1];
    ovf_ev  = '0;
    if (split) begin
      if (lo_adv_s) begin
        lo_n[0]   = lo_q[0] + 8'd1;
        ovf_ev[0] = &lo_q[0];
      end
      if (hi_adv_s) begin
        hi_n[0]   = hi_q[0] + 8'd1;
        ovf_ev[1] = &hi_q[0];
      end
    end else if (evt[0]) begin
      lo_n[0]   = st[0].lo;
      hi_n[0]   = st[0].hi;
      ovf_ev[0] = st[0].ovf;
    end
    if (!hold1 && evt[1]) begin
      lo_n[1]   = st[1].lo;
      hi_n[1]   = st[1].hi;
      ovf_ev[1] = st[1].ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int u = 0; u < NU; u++) begin
        lo_q[u]  <= '0;
        hi_q[u]  <= '0;
        cfg_q[u] <= '0;
      end
      run_q  <= '0;
      flag_q <= '0;
      fast_q <= '0;
    end else begin
      for (int u = 0; u < NU; u++) begin
        lo_q[u] <= (wr_en && addr == 3'(2*u))     ? wr_data : lo_n[u];
        hi_q[u] <= (wr_en && addr == 3'(2*u + 1)) ? wr_data : hi_n[u];
        if (wr_ctrl) begin
          run_q[u]  <= wr_data[4*u];
          flag_q[u] <= wr_data[4*u + 1];
          fast_q[u] <= wr_data[4*u + 2];
        end else if (ovf_ev[u]) begin
          flag_q[u] <= 1'b1;
        end else if (irq_ack[u]) begin
          flag_q[u] <= 1'b0;
        end
      end
      if (wr_en && addr == 3'd4) begin
        cfg_q[0] <= tmr_cfg_t'(wr_data[3:0]);
        cfg_q[1] <= tmr_cfg_t'(wr_data[7:4]);
      end
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rd_data = lo_q[0];
      3'd1:    rd_data = hi_q[0];
      3'd2:    rd_data = lo_q[1];
      3'd3:    rd_data = hi_q[1];
      3'd4:    rd_data = {cfg_q[1], cfg_q[0]};
      3'd5:    rd_data = {1'b0, fast_q[1], flag_q[1], run_q[1], 1'b0, fast_q[0], flag_q[0], run_q[0]};
      default: rd_data = 8'h00;
    endcase
  end

  assign ovf_flag = flag_q;

  // R3
  flag0_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[0]) |-> $past(ovf_ev[0] | wr_ctrl));

  // R10
  flag1_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[1]) |-> $past(ovf_ev[1] | wr_ctrl));

  // R11
  unit1_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold1 && !(wr_en && (addr == 3'd2 || addr == 3'd3))) |=>
      ($stable(lo_q[1]) && $stable(hi_q[1])));

  // R12
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack[0] && !ovf_ev[0] && !wr_ctrl) |=> !flag_q[0]);

  // R5
  reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ev[0] && cfg_q[0].mode == TM_RELOAD && !(wr_en && addr == 3'd0)) |=>
      (lo_q[0] == $past(hi_q[0])));

endmodule

// File: tb/dual_timer_tb.sv
module dual_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [1:0] cnt_in = 2'b11;
  logic [1:0] gate_pin = 2'b00;
  logic [1:0] irq_ack = 2'b00;
  logic [1:0] ovf_flag;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dual_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .cnt_in(cnt_in), .gate_pin(gate_pin), .irq_ack(irq_ack),
    .ovf_flag(ovf_flag));

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic reg_wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_all();
    reg_wr(3'd5, 8'h00);
    reg_wr(3'd4, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 6; a++) begin
      reg_rd(3'(a), v);
      chk($sformatf("R1 reg%0d", a), {8'h0, v}, 16'h0000);
    end
    chk("R1 flags", {14'h0, ovf_flag}, 16'h0000);
  endtask

  task automatic t_mode1();
    logic [7:0] lo, hi;
    reg_wr(3'd4, 8'h01);
    reg_wr(3'd0, 8'hFE);
    reg_wr(3'd1, 8'hFF);
    reg_wr(3'd5, 8'h05);
    wait_n(2);
    reg_rd(3'd0, lo); reg_rd(3'd1, hi);
    chk("R3 16-bit wrap", {hi, lo}, 16'h0000);
    chk("R3 flag0", {15'h0, ovf_flag[0]}, 16'h1);
    reg_rd(3'd4, lo);
    chk("R2 config readback", {8'h0, lo}, 16'h0001);
    reg_rd(3'd5, lo);
    chk("R2 control readback", {8'h0, lo}, 16'h0007);
    clear_all();
  endtask

  task automatic t_mode0();
    logic [7:0] lo, hi;
    reg_wr(3'd4, 8'h00);
    reg_wr(3'd0, 8'hFE);
    reg_wr(3'd1, 8'hFF);
    reg_wr(3'd5, 8'h05);
    wait_n(2);
    reg_rd(3'd0, lo); reg_rd(3'd1, hi);
    chk("R4 13-bit wrap keeps lo[7:5]", {hi, lo}, 16'h00E0);
    chk("R4 flag0", {15'h0, ovf_flag[0]}, 16'h1);
    clear_all();
  endtask

  task automatic t_mode2();
    logic [7:0] lo, hi;
    reg_wr(3'd4, 8'h02);
    reg_wr(3'd0, 8'hFE);
    reg_wr(3'd1, 8'h80);
    reg_wr(3'd5, 8'h05);
    wait_n(3);
    reg_rd(3'd0, lo); reg_rd(3'd1, hi);
    chk("R5 reload then count", {hi, lo}, 16'h8081);
    chk("R5 flag0", {15'h0, ovf_flag[0]}, 16'h1);
    clear_all();
  endtask

  task automatic t_counter();
    logic [7:0] lo;
    reg_wr(3'd4, 8'h05);
    reg_wr(3'd0, 8'h00);
    reg_wr(3'd1, 8'h00);
    reg_wr(3'd5, 8'h01);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); cnt_in[0] = 1'b0;
      wait_n(4);
      cnt_in[0] = 1'b1;
      wait_n(4);
    end
    wait_n(4);
    reg_rd(3'd0, lo);
    chk("R6 four falling edges", {8'h0, lo}, 16'h0004);
    clear_all();
  endtask

  task automatic t_gate();
    logic [7:0] lo;
    reg_wr(3'd4, 8'h09);
    reg_wr(3'd0, 8'h00);
    reg_wr(3'd1, 8'h00);
    gate_pin[0] = 1'b0;
    reg_wr(3'd5, 8'h05);
    wait_n(10);
    reg_rd(3'd0, lo);
    chk("R7 gate low blocks", {8'h0, lo}, 16'h0000);
    gate_pin[0] = 1'b1;
    wait_n(5);
    reg_rd(3'd0, lo);
    chk("R7 gate high counts", {8'h0, lo}, 16'h0005);
    gate_pin[0] = 1'b0;
    clear_all();
  endtask

  task automatic t_slow();
    logic [7:0] lo;
    reg_wr(3'd4, 8'h10);
    reg_wr(3'd2, 8'h00);
    reg_wr(3'd3, 8'h00);
    reg_wr(3'd5, 8'h10);
    wait_n(35);
    reg_rd(3'd2, lo);
    chk("R8 div12 after 35 clocks", {8'h0, lo}, 16'h0002);
    wait_n(1);
    reg_rd(3'd2, lo);
    chk("R8 div12 after 36 clocks", {8'h0, lo}, 16'h0003);
    clear_all();
  endtask

  task automatic t_split();
    logic [7:0] lo, hi, l1, h1;
    reg_wr(3'd4, 8'h13);
    reg_wr(3'd0, 8'hFE);
    reg_wr(3'd1, 8'hFF);
    reg_wr(3'd2, 8'h34);
    reg_wr(3'd3, 8'h12);
    reg_wr(3'd5, 8'h15);
    wait_n(2);
    reg_rd(3'd0, lo); reg_rd(3'd1, hi);
    chk("R9 split low byte wraps", {8'h0, lo}, 16'h0000);
    chk("R9 split flag0", {15'h0, ovf_flag[0]}, 16'h1);
    chk("R10 split high byte", {8'h0, hi}, 16'h0001);
    chk("R10 split flag1", {15'h0, ovf_flag[1]}, 16'h1);
    reg_rd(3'd2, l1); reg_rd(3'd3, h1);
    chk("R10 unit1 frozen", {h1, l1}, 16'h1234);
    clear_all();
  endtask

  task automatic t_hold1();
    logic [7:0] l1, h1;
    reg_wr(3'd4, 8'h31);
    reg_wr(3'd2, 8'h10);
    reg_wr(3'd3, 8'h00);
    reg_wr(3'd5, 8'h50);
    wait_n(5);
    reg_rd(3'd2, l1); reg_rd(3'd3, h1);
    chk("R11 unit1 mode3 holds", {h1, l1}, 16'h0010);
    reg_wr(3'd4, 8'h11);
    wait_n(4);
    reg_rd(3'd2, l1); reg_rd(3'd3, h1);
    chk("R11 unit1 resumes in mode1", {h1, l1}, 16'h0014);
    clear_all();
  endtask

  task automatic t_ack();
    reg_wr(3'd5, 8'h22);
    chk("R12 host sets flags", {14'h0, ovf_flag}, 16'h0003);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd5; wr_data = 8'h02; irq_ack = 2'b11;
    @(negedge clk);
    wr_en = 1'b0; irq_ack = 2'b00;
    chk("R12 write beats ack", {14'h0, ovf_flag}, 16'h0001);
    irq_ack[0] = 1'b1;
    @(negedge clk);
    irq_ack[0] = 1'b0;
    chk("R12 ack clears", {14'h0, ovf_flag}, 16'h0000);
    clear_all();
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
          failures++;
          $display("FAIL watchdog expired");
          $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
          $finish;
        end
      end
    join_none
    wait_n(3);
    rst_n = 1'b1;
    t_reset();
    t_mode1();
    t_mode0();
    t_mode2();
    t_counter();
    t_gate();
    t_slow();
    t_split();
    t_hold1();
    t_ack();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule